// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit holds the interrupt-enable register of a UART and turns five interrupt sources into one active-high request line and an 8-bit identification value. The sources are receive line errors, receive FIFO occupancy at or above its trigger, receive character timeout, transmit holding register empty and modem status change. When more than one enabled source is pending, only the most urgent is reported. Each source is cleared by the bus access that services it.

The FIFO storage, the serial shifters and the modem pins sit in neighbouring blocks, which feed this unit with levels and single-cycle strobes. Bus reads and writes of the related registers reach it as one-cycle strobes. The character timeout is measured in bit-time ticks from the baud generator. Because the tick rate follows the programmed divisor, the timeout always spans the same number of character times whatever the line speed.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0, the identification value reads 0xC1 and `irq` is low.
- R2: The identification value has bits [7:6] = 11 and bits [5:4] = 00. Bit 0 is 1 exactly when no enabled source is pending. Bits [3:0] carry the reported source: 0x6 line error, 0x4 receive data, 0xC character timeout, 0x2 transmit empty, 0x0 modem change, 0x1 nothing pending.
- R3: Enable bit 0 gates receive data and timeout, bit 1 gates transmit empty, bit 2 gates line error and bit 3 gates modem change. `irq` is the OR of all enabled pending sources. A masked source that is still pending shows up as soon as its enable bit is set.
- R4: Priority from highest to lowest is line error, receive data, character timeout, transmit empty, modem change.
- R5: A `ls_err_evt` pulse latches the line-error source. An `lsr_rd` strobe clears it. If a new event and the clear arrive in the same cycle, the event wins.
- R6: The receive-data source is pending while `rx_level` is nonzero and `rx_level >= rx_trig`. This includes the case where the two are equal.
- R7: The timeout source becomes pending once TO_CHARS*CHAR_BITS `baud_tick` pulses (40 by default) have arrived while the FIFO held data below trigger, with no `rx_push` and no `rbr_rd`. One tick fewer is not enough.
- R8: An `rbr_rd` strobe clears the timeout source and restarts its count. An `rx_push` restarts the count.
- R9: The transmit-empty source is set by a 0-to-1 change of `thr_empty`. It is also set by an enable write that changes bit 1 from 0 to 1 while `thr_empty` is high. A write that leaves bit 1 at 1 does not set it.
- R10: The transmit-empty source is cleared by `thr_wr`. It is also cleared by `iir_rd`, but only in a cycle where 0x2 is the reported code. A read while a higher source is reported leaves it pending.
- R11: The modem-change source follows the `msr_change` level and reports code 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_we | input | 1 | Enable-register write strobe |
| ier_din | input | 4 | Enable-register write data |
| ier_q | output | 4 | Enable-register contents |
| iir_rd | input | 1 | Identification-register read strobe |
| iir_q | output | 8 | Identification value |
| irq | output | 1 | Interrupt request, active high |
| lsr_rd | input | 1 | Line-status read strobe |
| rbr_rd | input | 1 | Receive data read strobe |
| thr_wr | input | 1 | Transmit holding write strobe |
| ls_err_evt | input | 1 | Overrun, framing error or break detected (pulse) |
| rx_push | input | 1 | New character written into the receive FIFO |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_trig | input | LVL_W | Receive FIFO trigger level |
| baud_tick | input | 1 | One pulse per bit time |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| msr_change | input | 1 | Modem status change pending (level) |

## Verification
A vector table sweeps enable masks against combinations of pending sources to expose a wrong priority chain or a mask applied to the wrong source. Such a design reports the wrong code, or raises `irq` while the mask is zero. Directed tests then probe the timeout at exactly one tick short of its limit and at the limit. They also check that an `rx_push` partway through restarts the count; an off-by-one counter or a missed restart fires early or late. The transmit-empty tests check that an identification read clears only a transmit-empty report and not one hidden behind a line error. They also check that a repeated enable write does not re-arm the source, and that an error and its clear in the same cycle leave the error pending. A design that gets these wrong drops interrupts or produces extra ones.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [3:0] {
      IID_MODEM   = 4'h0,
      IID_NONE    = 4'h1,
      IID_TXEMPTY = 4'h2,
      IID_RXDATA  = 4'h4,
      IID_LINE    = 4'h6,
      IID_RXTMO   = 4'hC
   } iid_e;

   localparam logic [1:0] IIR_FIFO_MARK = 2'b11;
   localparam int         NUM_SRC       = 5;

   // index of each source in the request vector; lower index is more urgent
   localparam int SRC_LINE    = 0;
   localparam int SRC_RXDATA  = 1;
   localparam int SRC_RXTMO   = 2;
   localparam int SRC_TXEMPTY = 3;
   localparam int SRC_MODEM   = 4;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic ls_evt,
   input  logic ls_clr,
   input  logic thr_empty,
   input  logic tx_arm,
   input  logic tx_ack,
   input  logic thr_wr,
   output logic ls_pend,
   output logic tx_pend
);
   logic empty_q;
   logic tx_set;

   assign tx_set = (thr_empty & ~empty_q) | tx_arm;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ls_pend <= 1'b0;
         tx_pend <= 1'b0;
         empty_q <= 1'b0;
      end else begin
         empty_q <= thr_empty;
         if (ls_evt)      ls_pend <= 1'b1;
         else if (ls_clr) ls_pend <= 1'b0;
         if (tx_set)                tx_pend <= 1'b1;
         else if (tx_ack || thr_wr) tx_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_char_timer.sv
module irq_char_timer #(
   parameter int LVL_W    = 5,
   parameter int TO_TICKS = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_trig,
   input  logic             rx_push,
   input  logic             rbr_rd,
   input  logic             baud_tick,
   output logic             tmo_pend
);
   localparam int TO_W = $clog2(TO_TICKS + 1);
   localparam logic [TO_W-1:0] LIMIT = TO_W'(TO_TICKS);

   logic [TO_W-1:0] cnt;
   logic            restart;
   logic            full;

   assign restart = rx_push | rbr_rd | (rx_level == '0);
   assign full    = (cnt == LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (restart)          cnt <= '0;
      else if (baud_tick && !full) cnt <= cnt + 1'b1;
   end

   assign tmo_pend = full & (rx_level < rx_trig);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_irq_pkg::*;
(
   input  logic [NUM_SRC-1:0] req,
   output iid_e               iid,
   output logic               any
);
   always_comb begin
      if      (req[SRC_LINE])    iid = IID_LINE;
      else if (req[SRC_RXDATA])  iid = IID_RXDATA;
      else if (req[SRC_RXTMO])   iid = IID_RXTMO;
      else if (req[SRC_TXEMPTY]) iid = IID_TXEMPTY;
      else if (req[SRC_MODEM])   iid = IID_MODEM;
      else                       iid = IID_NONE;
   end

   assign any = |req;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int LVL_W     = 5,
   parameter int CHAR_BITS = 10,
   parameter int TO_CHARS  = 4,
   parameter bit MODEM_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ier_we,
   input  logic [3:0]       ier_din,
   output logic [3:0]       ier_q,
   input  logic             iir_rd,
   output logic [7:0]       iir_q,
   output logic             irq,
   input  logic             lsr_rd,
   input  logic             rbr_rd,
   input  logic             thr_wr,
   input  logic             ls_err_evt,
   input  logic             rx_push,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_trig,
   input  logic             baud_tick,
   input  logic             thr_empty,
   input  logic             msr_change
);
   localparam int TO_TICKS = TO_CHARS * CHAR_BITS;

   initial begin : chk_params
      if (LVL_W < 2 || LVL_W > 8)          $error("LVL_W out of range");
      if (CHAR_BITS < 7 || CHAR_BITS > 12) $error("CHAR_BITS out of range");
      if (TO_CHARS < 1 || TO_CHARS > 16)   $error("TO_CHARS out of range");
   end

   logic [2:0]         ier_lo;
   logic               ier_ms;
   logic               ls_pend, tx_pend, tmo_pend, rda_pend, ms_pend;
   logic               tx_arm, tx_ack;
   logic [NUM_SRC-1:0] req;
   iid_e               iid;
   logic               any;

   always_ff @(posedge clk) begin
      if (!rst_n)      ier_lo <= '0;
      else if (ier_we) ier_lo <= ier_din[2:0];
   end

   generate
      if (MODEM_EN) begin : g_modem
         always_ff @(posedge clk) begin
            if (!rst_n)      ier_ms <= 1'b0;
            else if (ier_we) ier_ms <= ier_din[3];
         end
         assign ms_pend = msr_change;
      end else begin : g_no_modem
         assign ier_ms  = 1'b0;
         assign ms_pend = 1'b0;
      end
   endgenerate

   assign ier_q  = {ier_ms, ier_lo};
   assign tx_arm = ier_we & ier_din[1] & ~ier_lo[1] & thr_empty;
   assign tx_ack = iir_rd & (iid == IID_TXEMPTY);

   irq_src_latch u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .ls_evt    (ls_err_evt),
      .ls_clr    (lsr_rd),
      .thr_empty (thr_empty),
      .tx_arm    (tx_arm),
      .tx_ack    (tx_ack),
      .thr_wr    (thr_wr),
      .ls_pend   (ls_pend),
      .tx_pend   (tx_pend)
   );

   irq_char_timer #(.LVL_W(LVL_W), .TO_TICKS(TO_TICKS)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_level  (rx_level),
      .rx_trig   (rx_trig),
      .rx_push   (rx_push),
      .rbr_rd    (rbr_rd),
      .baud_tick (baud_tick),
      .tmo_pend  (tmo_pend)
   );

   assign rda_pend = (rx_level != '0) && (rx_level >= rx_trig);

   assign req[SRC_LINE]    = ls_pend  & ier_lo[2];
   assign req[SRC_RXDATA]  = rda_pend & ier_lo[0];
   assign req[SRC_RXTMO]   = tmo_pend & ier_lo[0];
   assign req[SRC_TXEMPTY] = tx_pend  & ier_lo[1];
   assign req[SRC_MODEM]   = ms_pend  & ier_ms;

   irq_prio_enc u_enc (
      .req (req),
      .iid (iid),
      .any (any)
   );

   assign irq   = any;
   assign iir_q = {IIR_FIFO_MARK, 2'b00, iid};
endmodule

// File: rtl/irq_ident_chk.sv
module irq_ident_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ier_we,
   input logic [3:0] ier_q,
   input logic       iir_rd,
   input logic [7:0] iir_q,
   input logic       irq,
   input logic       lsr_rd,
   input logic       rbr_rd,
   input logic       ls_err_evt,
   input logic       thr_empty
);
   AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> iir_q == 8'hC1);                                       // R2
   AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      ier_q == 4'h0 |-> !irq);                                        // R3
   AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_err_evt && ier_q[2] && !ier_we) |=> iir_q == 8'hC6);        // R4
   AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !ls_err_evt) |=> iir_q[3:0] != 4'h6);                // R5
   AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rbr_rd && iir_q == 8'hCC) |=> iir_q != 8'hCC);                 // R8
   AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(thr_empty) && ier_q[1] && !ier_we) |=> irq);             // R9
endmodule

bind uart_irq_ident irq_ident_chk u_chk (.*);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/100ps
module sim_uart_irq_ident;
   localparam int LVL_W = 5;
   localparam int TO_TICKS = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ier_we = 0, iir_rd = 0, lsr_rd = 0, rbr_rd = 0, thr_wr = 0;
   logic ls_err_evt = 0, rx_push = 0, baud_tick = 0, thr_empty = 0, msr_change = 0;
   logic [3:0] ier_din = '0;
   logic [LVL_W-1:0] rx_level = '0, rx_trig = '0;
   logic [3:0] ier_q;
   logic [7:0] iir_q;
   logic irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_irq_ident u0 (.*);

   // vector: ier(4) ls(1) level(5) trig(5) ms(1) expected iir(8)
   localparam int NV = 11;
   localparam logic [23:0] VEC [NV] = '{
      {4'h0, 1'b1, 5'd5,  5'd1,  1'b1, 8'hC1},  // R3 all masked
      {4'hF, 1'b1, 5'd5,  5'd1,  1'b1, 8'hC6},  // R4 line first
      {4'hF, 1'b0, 5'd5,  5'd4,  1'b1, 8'hC4},  // R4 data over modem
      {4'hF, 1'b0, 5'd3,  5'd4,  1'b1, 8'hC0},  // R11 below trigger
      {4'hB, 1'b1, 5'd0,  5'd1,  1'b0, 8'hC1},  // R3 line masked
      {4'h4, 1'b1, 5'd8,  5'd8,  1'b1, 8'hC6},  // R3 only line enabled
      {4'h1, 1'b0, 5'd8,  5'd8,  1'b0, 8'hC4},  // R6 level equals trigger
      {4'h1, 1'b0, 5'd7,  5'd8,  1'b0, 8'hC1},  // R6 one below trigger
      {4'h8, 1'b0, 5'd16, 5'd1,  1'b1, 8'hC0},  // R11 modem alone
      {4'h7, 1'b0, 5'd0,  5'd0,  1'b1, 8'hC1},  // R6 empty fifo, zero trigger
      {4'h1, 1'b0, 5'd16, 5'd16, 1'b1, 8'hC4}   // R6 full fifo
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FIFO check FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr_ier(input logic [3:0] v);
      @(negedge clk); ier_we = 1; ier_din = v;
      @(negedge clk); ier_we = 0;
   endtask

   // 0 ls_err_evt, 1 lsr_rd, 2 iir_rd, 3 rbr_rd, 4 thr_wr, 5 rx_push, 6 baud_tick
   task automatic strobe(input int which);
      @(negedge clk);
      case (which)
         0: ls_err_evt = 1; 1: lsr_rd = 1; 2: iir_rd = 1; 3: rbr_rd = 1;
         4: thr_wr = 1;     5: rx_push = 1; default: baud_tick = 1;
      endcase
      @(negedge clk);
      {ls_err_evt, lsr_rd, iir_rd, rbr_rd, thr_wr, rx_push, baud_tick} = '0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) strobe(6);
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("Watchdog FAIL R1: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      chk("R1 iir", iir_q, 8'hC1);
      chk("R1 ier", {4'h0, ier_q}, 8'h00);
      chk("R1 irq", {7'h0, irq}, 8'h00);

      for (int k = 0; k < NV; k++) begin
         wr_ier(VEC[k][23:20]);
         rx_level = VEC[k][18:14]; rx_trig = VEC[k][13:9]; msr_change = VEC[k][8];
         if (VEC[k][19]) strobe(0); else cyc();
         chk($sformatf("R2/R4 vector %0d iir", k), iir_q, VEC[k][7:0]);
         chk($sformatf("R3 vector %0d irq", k), {7'h0, irq}, {7'h0, VEC[k][7:0] != 8'hC1});
         strobe(1);
         msr_change = 0; rx_level = '0; rx_trig = '0;
         cyc();
      end

      // R3: masked line error surfaces once enabled
      wr_ier(4'h0); strobe(0);
      chk("R3 masked", iir_q, 8'hC1);
      wr_ier(4'h4);
      chk("R3 unmasked", iir_q, 8'hC6);
      strobe(1);
      chk("R5 cleared by lsr read", iir_q, 8'hC1);
      // R5: event and clear together
      @(negedge clk); ls_err_evt = 1; lsr_rd = 1;
      @(negedge clk); ls_err_evt = 0; lsr_rd = 0;
      chk("R5 event beats clear", iir_q, 8'hC6);
      strobe(1);

      // R7/R8 character timeout
      wr_ier(4'h1); rx_level = 5'd2; rx_trig = 5'd8;
      strobe(5);
      ticks(TO_TICKS - 1);
      chk("R7 one tick short", iir_q, 8'hC1);
      ticks(1);
      chk("R7 timeout", iir_q, 8'hCC);
      chk("R7 irq", {7'h0, irq}, 8'h01);
      strobe(3);
      chk("R8 cleared by data read", iir_q, 8'hC1);
      ticks(TO_TICKS - 1);
      strobe(5);
      ticks(TO_TICKS - 1);
      chk("R8 push restarts count", iir_q, 8'hC1);
      ticks(1);
      chk("R8 timeout after restart", iir_q, 8'hCC);
      rx_level = '0; cyc();
      chk("R7 empty fifo no timeout", iir_q, 8'hC1);

      // R9/R10 transmit empty
      wr_ier(4'h2);
      thr_empty = 1; cyc(); cyc();
      chk("R9 empty edge", iir_q, 8'hC2);
      strobe(2);
      chk("R10 iir read clears", iir_q, 8'hC1);
      thr_empty = 0; cyc(); thr_empty = 1; cyc(); cyc();
      chk("R9 second edge", iir_q, 8'hC2);
      strobe(4);
      chk("R10 thr write clears", iir_q, 8'hC1);
      wr_ier(4'h0);
      wr_ier(4'h2);
      chk("R9 enable while empty", iir_q, 8'hC2);
      wr_ier(4'h6);
      strobe(0);
      chk("R4 line over tx empty", iir_q, 8'hC6);
      strobe(2);
      strobe(1);
      chk("R10 hidden tx survives iir read", iir_q, 8'hC2);
      strobe(2);
      chk("R10 cleared when reported", iir_q, 8'hC1);
      wr_ier(4'h2);
      chk("R9 repeated enable no rearm", iir_q, 8'hC1);

      // R11 modem level
      wr_ier(4'h8); msr_change = 1; cyc();
      chk("R11 modem", iir_q, 8'hC0);
      msr_change = 0; cyc();
      chk("R11 modem gone", iir_q, 8'hC1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule